// File: doc/BRIEF.md
# LCD Line-Scan and Alternation Timing Generator

This block produces the row-scan timing for a passive-matrix LCD common driver. Every display-clock tick moves a line counter across 132 common rows. The row index that goes to the row drivers can run upward (0 to 131) or downward (131 to 0). At every frame start the block emits a one-clock field-start pulse. It also keeps the liquid-crystal alternation level, which inverts either once per frame or once every 4 × (a+1) lines.

All logic runs on the system clock `clk`. The display clock appears as single-cycle tick enables. In master mode with the internal source selected, the ticks come from `osc_tick_i`, gated by a sticky oscillator-on command. In every other mode they come from rising edges of `cl_i`. In master mode the block drives the timing pins. In slave mode it takes alternation and field-start from a master. `cl_i`, `fr_i` and `ca_i` are assumed synchronous to `clk`.

Scan direction, alternation mode and the line-group value are only staged. They become active at the next frame start, or at once while the block is held before the oscillator-on command.

Top module: `lcd_scan_timing`

## Requirements
- R1: While master and internal source are selected (`master_i`=1, `clksel_i`=1) and no oscillator-on command has been seen since reset, the block holds its state. `row_o` stays at the start row of the staged direction, `fr_o`=0 and `ca_o`=0, whatever ticks arrive. Reset leaves `fr_o`=0 and `ca_o`=0.
- R2: With `master_i`=1 and `clksel_i`=1, display ticks are `osc_tick_i` gated by the oscillator-on state. `cl_o` carries those gated ticks in the same cycle, and `cl_oe_o`=1. In any other mode `cl_oe_o`=0, `cl_o`=0, and a tick is a 0→1 change of `cl_i` between consecutive clocks.
- R3: There are 132 rows. Each tick advances the line count by one, and the count wraps from 131 to 0. `row_o` equals the line count when direction bit 0 (forward) is active, and 131 minus the line count when direction bit 1 (reverse) is active.
- R4: In master mode, `ca_o` is high for exactly the one clock that follows the tick which returns the line count to 0.
- R5: With `nline_en_i`=0 active, `fr_o` inverts once at each frame start and at no other time, so one alternation period spans two frames.
- R6: With `nline_en_i`=1 active and value a on `rev_a_i`, `fr_o` inverts after every 4 × (a+1) ticks. The line-group count restarts at each frame start, and `fr_o` is not reset at a frame start.
- R7: Changes on `dir_i`, `nline_en_i` and `rev_a_i` take effect only at the next frame start.
- R8: In slave mode (`master_i`=0), `fr_o` follows `fr_i` one clock later. `ca_i`=1 forces the line count to 0 on the next clock, and ticks from `cl_i` advance the line count. `ca_o` stays 0.
- R9: `timing_oe_o` equals `master_i`. It marks FR, CA and the other frame signals as driven by this block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| master_i | input | 1 | 1 = master, 0 = slave |
| clksel_i | input | 1 | 1 = internal tick source, 0 = external line clock |
| osc_on_cmd_i | input | 1 | One-cycle oscillator-on command (sticky until reset) |
| osc_tick_i | input | 1 | Internal oscillator tick enable |
| cl_i | input | 1 | External line clock level |
| cl_o | output | 1 | Line clock tick driven out in master/internal mode |
| cl_oe_o | output | 1 | Drive enable for `cl_o` |
| dir_i | input | 1 | Staged scan direction, 0 forward, 1 reverse |
| nline_en_i | input | 1 | Staged alternation mode, 1 = line-group inversion |
| rev_a_i | input | A_W | Staged line-group value a |
| fr_i | input | 1 | Alternation level from a master |
| ca_i | input | 1 | Field-start pulse from a master |
| fr_o | output | 1 | Alternation level |
| ca_o | output | 1 | Field-start pulse |
| row_o | output | ROW_W | Active common row index |
| timing_oe_o | output | 1 | Drive enable for frame timing signals |

## Verification
A wrong line count shows on `row_o` in the next clock. A count that wraps at the wrong value also moves the `ca_o` pulse and, in frame mode, the `fr_o` edge to the wrong tick. A faulty line-group counter shows as an `fr_o` inversion one or more ticks off the 4 × (a+1) grid, and at the latest it appears after the first group boundary of a frame. A missing frame-boundary hold on the staged settings shows as a jump of `row_o` in the middle of a frame in the clock after `dir_i` changes.

// File: rtl/lcd_scan_pkg.sv
package lcd_scan_pkg;
  typedef enum logic {
    SCAN_FWD = 1'b0,
    SCAN_REV = 1'b1
  } scan_dir_e;

  typedef struct packed {
    scan_dir_e dir;
    logic      nline_en;
  } scan_mode_t;
endpackage

// File: rtl/lcd_tick_src.sv
module lcd_tick_src (
  input  logic clk,
  input  logic rst_n,
  input  logic master_i,
  input  logic clksel_i,
  input  logic osc_on_cmd_i,
  input  logic osc_tick_i,
  input  logic cl_i,
  output logic tick_o,
  output logic hold_o,
  output logic cl_o,
  output logic cl_oe_o
);
  logic osc_on_q, osc_on_d;
  logic cl_q;
  logic int_src, int_tick, cl_rise;

  always_comb begin
    osc_on_d = osc_on_q | osc_on_cmd_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      osc_on_q <= 1'b0;
      cl_q     <= 1'b0;
    end else begin
      osc_on_q <= osc_on_d;
      cl_q     <= cl_i;
    end
  end

  assign int_src  = master_i & clksel_i;
  assign int_tick = int_src & osc_on_q & osc_tick_i;
  assign cl_rise  = cl_i & ~cl_q;
  assign tick_o   = int_src ? int_tick : cl_rise;
  assign hold_o   = int_src & ~osc_on_q;
  assign cl_o     = int_tick;
  assign cl_oe_o  = int_src;
endmodule

// File: rtl/lcd_line_ctr.sv
module lcd_line_ctr
  import lcd_scan_pkg::*;
#(
  parameter int ROWS = 132,
  parameter int A_W  = 4,
  localparam int LW  = $clog2(ROWS)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           tick_i,
  input  logic           hold_i,
  input  logic           slave_i,
  input  logic           ca_i,
  input  logic           dir_req_i,
  input  logic           nline_req_i,
  input  logic [A_W-1:0] a_req_i,
  output logic           frame_start_o,
  output scan_mode_t     mode_o,
  output logic [A_W-1:0] a_o,
  output logic [LW-1:0]  row_o,
  output logic           ca_o
);
  localparam logic [LW-1:0] LAST = LW'(ROWS - 1);

  logic [LW-1:0]  line_q, line_d;
  scan_mode_t     mode_q, mode_d, mode_req;
  logic [A_W-1:0] a_q, a_d;
  logic           ca_q, ca_d;
  logic           at_last, fs;

  assign mode_req = '{dir: scan_dir_e'(dir_req_i), nline_en: nline_req_i};
  assign at_last  = (line_q == LAST);
  assign fs       = slave_i ? ca_i : (tick_i & at_last);

  always_comb begin
    line_d = line_q;
    mode_d = mode_q;
    a_d    = a_q;
    ca_d   = 1'b0;
    if (hold_i) begin
      line_d = '0;
      mode_d = mode_req;
      a_d    = a_req_i;
    end else begin
      ca_d = fs & ~slave_i;
      if (fs) begin
        line_d = '0;
        mode_d = mode_req;
        a_d    = a_req_i;
      end else if (tick_i) begin
        line_d = at_last ? '0 : line_q + LW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_q <= '0;
      mode_q <= '{dir: SCAN_FWD, nline_en: 1'b0};
      a_q    <= '0;
      ca_q   <= 1'b0;
    end else begin
      line_q <= line_d;
      mode_q <= mode_d;
      a_q    <= a_d;
      ca_q   <= ca_d;
    end
  end

  assign frame_start_o = fs;
  assign mode_o        = mode_q;
  assign a_o           = a_q;
  assign ca_o          = ca_q;
  assign row_o         = (mode_q.dir == SCAN_REV) ? (LAST - line_q) : line_q;

  // R3
  line_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    line_q <= LAST);

  // R4
  ca_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ca_q |=> !ca_q);

  // R1
  hold_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hold_i |=> (line_q == '0 && !ca_q));

  // R7
  mode_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!fs && !hold_i) |=> ($stable(mode_q) && $stable(a_q)));
endmodule

// File: rtl/lcd_alt_gen.sv
module lcd_alt_gen #(
  parameter int A_W = 4,
  localparam int NW = A_W + 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           tick_i,
  input  logic           frame_start_i,
  input  logic           hold_i,
  input  logic           slave_i,
  input  logic           fr_i,
  input  logic           nline_en_i,
  input  logic [A_W-1:0] a_i,
  output logic           fr_o
);
  logic          fr_q, fr_d;
  logic [NW-1:0] nl_q, nl_d;
  logic          blk_end;

  assign blk_end = (nl_q == {a_i, 2'b11});

  always_comb begin
    fr_d = fr_q;
    nl_d = nl_q;
    if (hold_i) begin
      fr_d = 1'b0;
      nl_d = '0;
    end else if (slave_i) begin
      fr_d = fr_i;
      nl_d = '0;
    end else begin
      if (tick_i) begin
        if (nline_en_i) fr_d = fr_q ^ blk_end;
        else            fr_d = fr_q ^ frame_start_i;
      end
      if (frame_start_i || (tick_i && nline_en_i && blk_end)) nl_d = '0;
      else if (tick_i && nline_en_i)                          nl_d = nl_q + NW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fr_q <= 1'b0;
      nl_q <= '0;
    end else begin
      fr_q <= fr_d;
      nl_q <= nl_d;
    end
  end

  assign fr_o = fr_q;

  // R5
  fr_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold_i && !slave_i && !nline_en_i && !frame_start_i) |=> $stable(fr_q));

  // R6
  fr_nline_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold_i && !slave_i && nline_en_i && !(tick_i && blk_end)) |=> $stable(fr_q));

  // R1
  hold_fr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hold_i |=> !fr_q);
endmodule

// File: rtl/lcd_scan_timing.sv
module lcd_scan_timing
  import lcd_scan_pkg::*;
#(
  parameter int ROWS   = 132,
  parameter int A_W    = 4,
  localparam int ROW_W = $clog2(ROWS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             master_i,
  input  logic             clksel_i,
  input  logic             osc_on_cmd_i,
  input  logic             osc_tick_i,
  input  logic             cl_i,
  output logic             cl_o,
  output logic             cl_oe_o,
  input  logic             dir_i,
  input  logic             nline_en_i,
  input  logic [A_W-1:0]   rev_a_i,
  input  logic             fr_i,
  input  logic             ca_i,
  output logic             fr_o,
  output logic             ca_o,
  output logic [ROW_W-1:0] row_o,
  output logic             timing_oe_o
);
  logic           rst_s0, rst_s1;
  logic           tick, hold, fs;
  scan_mode_t     mode;
  logic [A_W-1:0] a_act;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s0 <= 1'b0;
      rst_s1 <= 1'b0;
    end else begin
      rst_s0 <= 1'b1;
      rst_s1 <= rst_s0;
    end
  end

  lcd_tick_src u_src (
    .clk          (clk),
    .rst_n        (rst_s1),
    .master_i     (master_i),
    .clksel_i     (clksel_i),
    .osc_on_cmd_i (osc_on_cmd_i),
    .osc_tick_i   (osc_tick_i),
    .cl_i         (cl_i),
    .tick_o       (tick),
    .hold_o       (hold),
    .cl_o         (cl_o),
    .cl_oe_o      (cl_oe_o)
  );

  lcd_line_ctr #(.ROWS(ROWS), .A_W(A_W)) u_line (
    .clk           (clk),
    .rst_n         (rst_s1),
    .tick_i        (tick),
    .hold_i        (hold),
    .slave_i       (~master_i),
    .ca_i          (ca_i),
    .dir_req_i     (dir_i),
    .nline_req_i   (nline_en_i),
    .a_req_i       (rev_a_i),
    .frame_start_o (fs),
    .mode_o        (mode),
    .a_o           (a_act),
    .row_o         (row_o),
    .ca_o          (ca_o)
  );

  lcd_alt_gen #(.A_W(A_W)) u_alt (
    .clk           (clk),
    .rst_n         (rst_s1),
    .tick_i        (tick),
    .frame_start_i (fs),
    .hold_i        (hold),
    .slave_i       (~master_i),
    .fr_i          (fr_i),
    .nline_en_i    (mode.nline_en),
    .a_i           (a_act),
    .fr_o          (fr_o)
  );

  assign timing_oe_o = master_i;
endmodule

// File: tb/sim_lcd_scan_timing.sv
module sim_lcd_scan_timing;
  localparam int ROWS = 132;
  localparam int A_W  = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic master, clksel, on_cmd, otick, cl, dir, nen, fr_in, ca_in;
  logic [A_W-1:0] a;
  logic cl_o, cl_oe, fr_o, ca_o, toe;
  logic [7:0] row_o;

  int tests = 0, fails = 0;
  int m_line, m_a, m_nl;
  bit m_dir, m_en, m_fr, m_ca, m_on, m_clq;

  always #4 clk = ~clk;

  lcd_scan_timing #(.ROWS(ROWS), .A_W(A_W)) u0 (
    .clk(clk), .rst_n(rst_n), .master_i(master), .clksel_i(clksel),
    .osc_on_cmd_i(on_cmd), .osc_tick_i(otick), .cl_i(cl), .cl_o(cl_o),
    .cl_oe_o(cl_oe), .dir_i(dir), .nline_en_i(nen), .rev_a_i(a),
    .fr_i(fr_in), .ca_i(ca_in), .fr_o(fr_o), .ca_o(ca_o), .row_o(row_o),
    .timing_oe_o(toe)
  );

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  function automatic int exp_row(input bit d, input int line);
    return d ? (ROWS - 1 - line) : line;
  endfunction

  // one clock: inputs already driven at the falling edge
  task automatic step();
    bit src_int, tk, hold, fs, slave, blk;
    bit cfg_pending;
    int exp_clo;
    #1;
    src_int = master && clksel;
    exp_clo = (src_int && m_on && otick) ? 1 : 0;
    chk(cl_o == exp_clo[0], "R2 cl_o", int'(cl_o), exp_clo);
    tk    = src_int ? (m_on && otick) : (cl && !m_clq);
    hold  = src_int && !m_on;
    slave = !master;
    fs    = slave ? ca_in : (tk && m_line == ROWS - 1);
    blk   = (m_nl == 4 * (m_a + 1) - 1);
    cfg_pending = (dir != m_dir);
    if (hold) begin
      m_line = 0; m_dir = dir; m_en = nen; m_a = int'(a); m_nl = 0; m_fr = 0; m_ca = 0;
    end else begin
      m_ca = fs && !slave;
      if (slave) m_fr = fr_in;
      else if (tk) m_fr = m_en ? (m_fr ^ blk) : (m_fr ^ fs);
      if (slave || fs || (tk && m_en && blk)) m_nl = 0;
      else if (tk && m_en) m_nl = m_nl + 1;
      if (fs) begin
        m_line = 0; m_dir = dir; m_en = nen; m_a = int'(a);
      end else if (tk) begin
        m_line = (m_line == ROWS - 1) ? 0 : m_line + 1;
      end
    end
    m_on  = m_on || on_cmd;
    m_clq = cl;
    @(posedge clk);
    @(negedge clk);
    if (hold)
      chk(row_o == 8'(exp_row(m_dir, m_line)), "R1 hold row", int'(row_o), exp_row(m_dir, m_line));
    else if (slave)
      chk(row_o == 8'(exp_row(m_dir, m_line)), "R8 slave row", int'(row_o), exp_row(m_dir, m_line));
    else if (cfg_pending)
      chk(row_o == 8'(exp_row(m_dir, m_line)), "R7 staged dir", int'(row_o), exp_row(m_dir, m_line));
    else
      chk(row_o == 8'(exp_row(m_dir, m_line)), "R3 row", int'(row_o), exp_row(m_dir, m_line));
    if (slave)      chk(fr_o == m_fr, "R8 fr follow", int'(fr_o), int'(m_fr));
    else if (m_en)  chk(fr_o == m_fr, "R6 fr nline", int'(fr_o), int'(m_fr));
    else            chk(fr_o == m_fr, "R5 fr frame", int'(fr_o), int'(m_fr));
    chk(ca_o == m_ca, "R4 ca", int'(ca_o), int'(m_ca));
    chk(toe == master, "R9 timing_oe", int'(toe), int'(master));
    chk(cl_oe == (master && clksel), "R2 cl_oe", int'(cl_oe), int'(master && clksel));
  endtask

  task automatic run(input int n, input int tick_pct);
    for (int i = 0; i < n; i++) begin
      on_cmd = 1'b0;
      otick  = ($urandom % 100) < tick_pct;
      cl     = (master && clksel) ? 1'b0 : ~cl & (($urandom % 100) < tick_pct);
      step();
    end
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    master = 1; clksel = 1; on_cmd = 0; otick = 0; cl = 0;
    dir = 0; nen = 0; a = '0; fr_in = 0; ca_in = 0;
    m_line = 0; m_dir = 0; m_en = 0; m_a = 0; m_nl = 0; m_fr = 0; m_ca = 0; m_on = 0; m_clq = 0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(fr_o == 1'b0, "R1 reset fr", int'(fr_o), 0);
    chk(ca_o == 1'b0, "R1 reset ca", int'(ca_o), 0);
    chk(row_o == 8'd0, "R1 reset row", int'(row_o), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1: ticks ignored before oscillator-on; staged reverse applies while held
    dir = 1;
    run(40, 80);
    dir = 0;
    run(10, 80);
    on_cmd = 1; otick = 0; step();
    // R3/R4/R5: forward frame mode
    run(900, 60);
    // R7: direction change in mid-frame
    dir = 1;
    run(700, 70);
    // R6: line-group mode, smallest and largest a, then random values
    nen = 1; a = '0;
    run(600, 70);
    a = 4'hF;
    run(700, 80);
    for (int k = 0; k < 4; k++) begin
      a = 4'($urandom);
      dir = 1'($urandom);
      run(500, 75);
    end
    nen = 0;
    run(400, 90);
    // R2: master with external line clock
    clksel = 0;
    run(900, 50);
    // R8: slave mode
    master = 0; clksel = 1;
    for (int i = 0; i < 1200; i++) begin
      otick = 1'($urandom);
      cl    = ~cl & (($urandom % 100) < 50);
      fr_in = (($urandom % 100) < 10) ? ~fr_in : fr_in;
      ca_in = ($urandom % 100) < 2;
      step();
    end
    // R8: directed resync with a field-start input
    ca_in = 1; cl = 0; step();
    ca_in = 0;
    chk(row_o == 8'(exp_row(m_dir, 0)), "R8 resync", int'(row_o), exp_row(m_dir, 0));
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule